// File: doc/BRIEF.md
# Trim Register with Try and Blow Fuse Emulation

This block keeps a six-bit switchpoint trim value and a single lock bit. Each one is backed by emulated one-time fuses. A pulse decoder sits upstream and delivers single-cycle strobes: a register-select strobe that carries the decoded key, a strobe that enters blow mode, an addressing strobe for each mid-level pulse, a blow strobe for a long high pulse, and a power-cycle strobe. In try mode the block steps a temporary code. With the up key the trim field shows that code. With the down key it shows the bitwise complement. The sensor core can therefore be measured at each step before anything is made permanent.

In blow mode the addressing strobes walk a one-hot pointer across the field. Each blow strobe sets the single fuse that the pointer selects. Fuses are sticky registers. A power cycle discards the try code and the open session but keeps every blown bit. The lock fuse shuts off every register except fuse check. Fuse check stays available before and after lock, and it raises a flag when a marginal-fuse indication arrives while one of the two check codes is selected. The only thing that clears the fuses is the synchronous reset, which stands for a factory-fresh part.

Top module: `trim_fuse_reg`

## Requirements
- R1: After reset, trim_out is 0, locked is 0 and fuse_chk_flag is 0. Reset also clears every fuse. Every output is registered and shows the effect of a strobe one clock after the edge that accepts it.
- R2: A select strobe with key 0 opens an up-counting trim session in try mode, with the code at 1. A select with any key other than 0, 1 or 7 opens no session.
- R3: In a try-mode trim session, each addressing strobe raises the code by one and saturates at 63. With key 0 the try field equals the code.
- R4: With key 1 the try field is the bitwise inverse of the code. Code 1 shows 111110 and code 63 shows 000000.
- R5: After the blow-mode strobe, the address starts at 000000. N addressing strobes select only bit N−1 for N from 1 to 6. A seventh strobe or any later one leaves no bit selected, and a blow strobe then changes nothing.
- R6: A blow strobe in a key 0 or key 1 blow session sets exactly the addressed trim fuse. Fuses never clear, and later blows add further bits.
- R7: A power-cycle strobe ends the session and discards the try code. The blown trim fuses and the lock fuse are kept.
- R8: Under key 7 in blow mode, four addressing strobes (bit 3) followed by a blow strobe set the lock. A blow at any other address under key 7 does not set it.
- R9: Once the lock is set, selects with key 0 or key 1 are refused and key 7 can no longer enter blow mode. The trim output stays at the blown value whatever addressing, mode and blow strobes follow.
- R10: Under key 7 in try mode, fuse_chk_flag follows marginal_in only while the code is 7 (low threshold) or 15 (high threshold). It is 0 for every other code, and this holds both before and after lock.
- R11: trim_out is the blown-fuse value ORed with the try field while a key 0 or key 1 try session is open. In blow mode or with no session, it is the blown-fuse value alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears fuses too |
| pwr_cycle | input | 1 | Supply-cycle strobe |
| sel_stb | input | 1 | Register-select strobe, end of the closing high pulse |
| sel_key | input | 4 | Key decoded with sel_stb |
| mode_stb | input | 1 | Blow-mode selection strobe |
| addr_stb | input | 1 | Addressing pulse strobe, falling edge |
| blow_stb | input | 1 | Blow pulse strobe |
| marginal_in | input | 1 | Marginal-fuse indication used by fuse check |
| trim_out | output | 6 | Effective trim value |
| locked | output | 1 | Lock fuse state |
| fuse_chk_flag | output | 1 | Fuse-check result |

## Verification
The trim path is driven in four ways: up-counting runs long enough to reach saturation, down-counting runs that show whether the inversion is applied, try sessions layered over blown fuses that expose the OR, and blow sequences with in-range, overrun and repeated addresses that separate shifting from counting and one fuse from many. The lock is attempted once at a wrong address and once at bit 3, then probed with every refused access. Fuse check is stepped through the codes on both sides of 7 and 15, with marginal_in toggled, before and after lock. A behavioural model in the bench predicts all three outputs on every cycle across these patterns.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef enum logic [1:0] {
    SESS_NONE = 2'd0,
    SESS_UP   = 2'd1,
    SESS_DN   = 2'd2,
    SESS_CHK  = 2'd3
  } sess_e;
endpackage

// File: rtl/trim_session.sv
module trim_session
  import trim_pkg::*;
#(
  parameter int KEY_W   = 4,
  parameter int KEY_UP  = 0,
  parameter int KEY_DN  = 1,
  parameter int KEY_CHK = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_cycle,
  input  logic             sel_stb,
  input  logic [KEY_W-1:0] sel_key,
  input  logic             mode_stb,
  input  logic             addr_stb,
  input  logic             blow_stb,
  input  logic             lock_fuse,
  output sess_e            sess,
  output logic             blow_mode,
  output logic             q_sel,
  output logic             q_mode,
  output logic             q_addr,
  output logic             q_blow
);
  sess_e sess_next;

  // Key decode; a locked part refuses the trim keys.
  always_comb begin
    if (sel_key == KEY_W'(KEY_UP) && !lock_fuse)      sess_next = SESS_UP;
    else if (sel_key == KEY_W'(KEY_DN) && !lock_fuse) sess_next = SESS_DN;
    else if (sel_key == KEY_W'(KEY_CHK))              sess_next = SESS_CHK;
    else                                              sess_next = SESS_NONE;
  end

  // Strobe priority: power cycle, select, mode, addressing, blow.
  always_comb begin
    q_sel  = sel_stb & ~pwr_cycle;
    q_mode = mode_stb & ~pwr_cycle & ~sel_stb & (sess != SESS_NONE)
             & ~((sess == SESS_CHK) & lock_fuse);
    q_addr = addr_stb & ~pwr_cycle & ~sel_stb & ~mode_stb & (sess != SESS_NONE);
    q_blow = blow_stb & ~pwr_cycle & ~sel_stb & ~mode_stb & ~addr_stb
             & (sess != SESS_NONE) & blow_mode;
  end

  always_ff @(posedge clk) begin
    if (rst || pwr_cycle) begin
      sess      <= SESS_NONE;
      blow_mode <= 1'b0;
    end else if (q_sel) begin
      sess      <= sess_next;
      blow_mode <= 1'b0;
    end else if (q_mode) begin
      blow_mode <= 1'b1;
    end
  end
endmodule

// File: rtl/trim_field.sv
module trim_field #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pwr_cycle,
  input  logic         q_sel,
  input  logic         q_mode,
  input  logic         q_addr,
  input  logic         blow_mode,
  output logic [W-1:0] try_code,
  output logic [W-1:0] blow_addr
);
  localparam logic [W-1:0] CODE_MAX = {W{1'b1}};
  localparam logic [W-1:0] CODE_ONE = W'(1);

  logic started;

  always_ff @(posedge clk) begin
    if (rst || pwr_cycle) begin
      try_code  <= '0;
      blow_addr <= '0;
      started   <= 1'b0;
    end else if (q_sel) begin
      try_code  <= CODE_ONE;
      blow_addr <= '0;
      started   <= 1'b0;
    end else if (q_mode) begin
      blow_addr <= '0;
      started   <= 1'b0;
    end else if (q_addr) begin
      if (blow_mode) begin
        // One-hot walk: first pulse lands on bit 0, then shifts out.
        blow_addr <= started ? {blow_addr[W-2:0], 1'b0} : CODE_ONE;
        started   <= 1'b1;
      end else if (try_code != CODE_MAX) begin
        try_code <= try_code + CODE_ONE;
      end
    end
  end
endmodule

// File: rtl/trim_fuse_bank.sv
module trim_fuse_bank
  import trim_pkg::*;
#(
  parameter int W        = 6,
  parameter int LOCK_BIT = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         q_blow,
  input  sess_e        sess,
  input  logic [W-1:0] blow_addr,
  output logic [W-1:0] trim_fuse,
  output logic         lock_fuse
);
  logic trim_sess;
  assign trim_sess = (sess == SESS_UP) || (sess == SESS_DN);

  for (genvar i = 0; i < W; i++) begin : g_fuse
    always_ff @(posedge clk) begin
      if (rst)
        trim_fuse[i] <= 1'b0;
      else if (q_blow && trim_sess && blow_addr[i])
        trim_fuse[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      lock_fuse <= 1'b0;
    else if (q_blow && (sess == SESS_CHK) && blow_addr[LOCK_BIT])
      lock_fuse <= 1'b1;
  end
endmodule

// File: rtl/trim_fuse_reg.sv
module trim_fuse_reg
  import trim_pkg::*;
#(
  parameter int W        = 6,
  parameter int KEY_W    = 4,
  parameter int KEY_UP   = 0,
  parameter int KEY_DN   = 1,
  parameter int KEY_CHK  = 7,
  parameter int LOCK_BIT = 3,
  parameter int CHK_LO   = 7,
  parameter int CHK_HI   = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_cycle,
  input  logic             sel_stb,
  input  logic [KEY_W-1:0] sel_key,
  input  logic             mode_stb,
  input  logic             addr_stb,
  input  logic             blow_stb,
  input  logic             marginal_in,
  output logic [W-1:0]     trim_out,
  output logic             locked,
  output logic             fuse_chk_flag
);
  sess_e        sess;
  logic         blow_mode;
  logic         q_sel, q_mode, q_addr, q_blow;
  logic [W-1:0] try_code, blow_addr, trim_fuse;
  logic         lock_fuse;
  logic [W-1:0] try_field;
  logic         try_on, chk_hit;

  trim_session #(
    .KEY_W(KEY_W), .KEY_UP(KEY_UP), .KEY_DN(KEY_DN), .KEY_CHK(KEY_CHK)
  ) u_sess (
    .clk(clk), .rst(rst), .pwr_cycle(pwr_cycle), .sel_stb(sel_stb),
    .sel_key(sel_key), .mode_stb(mode_stb), .addr_stb(addr_stb),
    .blow_stb(blow_stb), .lock_fuse(lock_fuse), .sess(sess),
    .blow_mode(blow_mode), .q_sel(q_sel), .q_mode(q_mode),
    .q_addr(q_addr), .q_blow(q_blow)
  );

  trim_field #(.W(W)) u_field (
    .clk(clk), .rst(rst), .pwr_cycle(pwr_cycle), .q_sel(q_sel),
    .q_mode(q_mode), .q_addr(q_addr), .blow_mode(blow_mode),
    .try_code(try_code), .blow_addr(blow_addr)
  );

  trim_fuse_bank #(.W(W), .LOCK_BIT(LOCK_BIT)) u_bank (
    .clk(clk), .rst(rst), .q_blow(q_blow), .sess(sess),
    .blow_addr(blow_addr), .trim_fuse(trim_fuse), .lock_fuse(lock_fuse)
  );

  always_comb begin
    try_field = (sess == SESS_DN) ? ~try_code : try_code;
    try_on    = ((sess == SESS_UP) || (sess == SESS_DN)) && !blow_mode;
    chk_hit   = (sess == SESS_CHK) && !blow_mode &&
                ((try_code == W'(CHK_LO)) || (try_code == W'(CHK_HI)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trim_out      <= '0;
      locked        <= 1'b0;
      fuse_chk_flag <= 1'b0;
    end else begin
      trim_out      <= trim_fuse | (try_on ? try_field : '0);
      locked        <= lock_fuse;
      fuse_chk_flag <= chk_hit & marginal_in;
    end
  end
endmodule

// File: rtl/trim_fuse_reg_chk.sv
module trim_fuse_reg_chk #(
  parameter int W = 6
) (
  input logic         clk,
  input logic         rst,
  input logic         pwr_cycle,
  input logic         sel_stb,
  input logic         addr_stb,
  input logic         marginal_in,
  input logic [W-1:0] try_code,
  input logic [W-1:0] blow_addr,
  input logic [W-1:0] trim_fuse,
  input logic         lock_fuse,
  input logic         fuse_chk_flag
);
  a_r6_fuse_sticky: assert property (@(posedge clk) disable iff (rst)
    ((trim_fuse & $past(trim_fuse)) == $past(trim_fuse)));

  a_r6_one_fuse_per_blow: assert property (@(posedge clk) disable iff (rst)
    ($countones(trim_fuse ^ $past(trim_fuse)) <= 1));

  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(lock_fuse) |-> lock_fuse);

  a_r5_addr_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(blow_addr));

  a_r3_code_holds: assert property (@(posedge clk) disable iff (rst)
    (!addr_stb && !sel_stb && !pwr_cycle) |=> $stable(try_code));

  a_r9_trim_frozen_when_locked: assert property (@(posedge clk) disable iff (rst)
    lock_fuse |=> $stable(trim_fuse));

  a_r10_flag_needs_marginal: assert property (@(posedge clk) disable iff (rst)
    fuse_chk_flag |-> $past(marginal_in));
endmodule

bind trim_fuse_reg trim_fuse_reg_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .pwr_cycle(pwr_cycle), .sel_stb(sel_stb),
  .addr_stb(addr_stb), .marginal_in(marginal_in), .try_code(try_code),
  .blow_addr(blow_addr), .trim_fuse(trim_fuse), .lock_fuse(lock_fuse),
  .fuse_chk_flag(fuse_chk_flag)
);

// File: tb/tb_trim_fuse_reg.sv
`timescale 1ns/1ps
module tb_trim_fuse_reg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwr_cycle = 1'b0, sel_stb = 1'b0, mode_stb = 1'b0;
  logic       addr_stb = 1'b0, blow_stb = 1'b0, marginal_in = 1'b0;
  logic [3:0] sel_key = '0;
  logic [5:0] trim_out;
  logic       locked, fuse_chk_flag;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  trim_fuse_reg dut (
    .clk(clk), .rst(rst), .pwr_cycle(pwr_cycle), .sel_stb(sel_stb),
    .sel_key(sel_key), .mode_stb(mode_stb), .addr_stb(addr_stb),
    .blow_stb(blow_stb), .marginal_in(marginal_in), .trim_out(trim_out),
    .locked(locked), .fuse_chk_flag(fuse_chk_flag)
  );

  // Behavioural reference: session 0 none, 1 up, 2 down, 3 check.
  int m_sess = 0, m_code = 0, m_apos = 0, m_fuse = 0;
  bit m_blow = 0, m_lock = 0, m_live = 0;
  int e_trim = 0;
  bit e_lock = 0, e_flag = 0;

  always @(posedge clk) begin
    m_live = 1;
    if (rst) begin
      m_sess = 0; m_code = 0; m_apos = 0; m_fuse = 0; m_blow = 0; m_lock = 0;
      e_trim = 0; e_lock = 0; e_flag = 0;
    end else begin
      e_trim = m_fuse;
      if ((m_sess == 1 || m_sess == 2) && !m_blow)
        e_trim = m_fuse | ((m_sess == 1) ? m_code : (63 - m_code));
      e_lock = m_lock;
      e_flag = (m_sess == 3) && !m_blow && (m_code == 7 || m_code == 15) && marginal_in;
      if (pwr_cycle) begin
        m_sess = 0; m_blow = 0; m_code = 0; m_apos = 0;
      end else if (sel_stb) begin
        if (sel_key == 0 && !m_lock)      m_sess = 1;
        else if (sel_key == 1 && !m_lock) m_sess = 2;
        else if (sel_key == 7)            m_sess = 3;
        else                              m_sess = 0;
        m_blow = 0; m_code = 1; m_apos = 0;
      end else if (mode_stb) begin
        if (m_sess != 0 && !(m_sess == 3 && m_lock)) begin
          m_blow = 1; m_apos = 0;
        end
      end else if (addr_stb) begin
        if (m_sess != 0) begin
          if (m_blow) m_apos = (m_apos < 7) ? m_apos + 1 : 7;
          else if (m_code < 63) m_code = m_code + 1;
        end
      end else if (blow_stb) begin
        if (m_sess != 0 && m_blow && m_apos >= 1 && m_apos <= 6) begin
          if (m_sess != 3) m_fuse = m_fuse | (1 << (m_apos - 1));
          else if (m_apos == 4) m_lock = 1;
        end
      end
    end
  end

  // Cycle compare against the model.
  always @(negedge clk) begin
    if (m_live) begin
      checks++;
      if (trim_out !== 6'(e_trim) || locked !== e_lock || fuse_chk_flag !== e_flag) begin
        errors++;
        $display("FAIL %s model: trim=%0d/%0d lock=%0b/%0b flag=%0b/%0b (actual/expected)",
                 cur_req, trim_out, e_trim, locked, e_lock, fuse_chk_flag, e_flag);
      end
    end
  end

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sel(int key);
    @(negedge clk); sel_stb = 1'b1; sel_key = 4'(key);
    @(negedge clk); sel_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_mode();
    @(negedge clk); mode_stb = 1'b1;
    @(negedge clk); mode_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic addr(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); addr_stb = 1'b1;
      @(negedge clk); addr_stb = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic blow();
    @(negedge clk); blow_stb = 1'b1;
    @(negedge clk); blow_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic pcycle();
    @(negedge clk); pwr_cycle = 1'b1;
    @(negedge clk); pwr_cycle = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    cur_req = "R1";
    chk("R1 trim after reset", trim_out, 0);
    chk("R1 lock after reset", locked, 0);
    chk("R1 flag after reset", fuse_chk_flag, 0);
    @(negedge clk); rst = 1'b0;
    idle(2);

    cur_req = "R2";
    sel(0);   chk("R2 up select code 1", trim_out, 1);
    sel(5);   chk("R2 unknown key no session", trim_out, 0);

    cur_req = "R3";
    sel(0); addr(3); chk("R3 code 4", trim_out, 4);
    addr(70);        chk("R3 saturate 63", trim_out, 63);

    cur_req = "R4";
    sel(1);   chk("R4 down code 1 inverted", trim_out, 62);
    addr(62); chk("R4 down code 63", trim_out, 0);

    cur_req = "R11";
    sel(0); pulse_mode(); chk("R11 blow mode hides try", trim_out, 0);

    cur_req = "R6";
    addr(3); blow(); chk("R6 fuse bit 2", trim_out, 4);

    cur_req = "R7";
    pcycle(); chk("R7 fuse kept over power cycle", trim_out, 4);

    cur_req = "R11";
    sel(0);  chk("R11 fuse OR code 1", trim_out, 5);
    addr(1); chk("R11 fuse OR code 2", trim_out, 6);
    sel(1);  chk("R11 fuse OR inverted code 1", trim_out, 62);

    cur_req = "R6";
    sel(0); pulse_mode(); addr(1); blow();
    chk("R6 second fuse accumulates", trim_out, 5);

    cur_req = "R5";
    sel(1); pulse_mode(); addr(7); blow();
    chk("R5 shifted-out address blows nothing", trim_out, 5);
    sel(0); pulse_mode(); blow();
    chk("R5 empty address blows nothing", trim_out, 5);

    cur_req = "R10";
    marginal_in = 1'b1;
    sel(7);  chk("R10 code 1 no flag", fuse_chk_flag, 0);
    addr(6); chk("R10 code 7 flag before lock", fuse_chk_flag, 1);
    marginal_in = 1'b0;

    cur_req = "R8";
    sel(7); pulse_mode(); addr(3); blow();
    chk("R8 bit 2 does not lock", locked, 0);
    sel(7); pulse_mode(); addr(4); blow();
    chk("R8 bit 3 locks", locked, 1);

    cur_req = "R7";
    pcycle(); chk("R7 lock kept over power cycle", locked, 1);

    cur_req = "R9";
    sel(0); chk("R9 up key refused", trim_out, 5);
    addr(3); pulse_mode(); addr(2); blow();
    chk("R9 refused session blows nothing", trim_out, 5);
    sel(1); addr(2); chk("R9 down key refused", trim_out, 5);
    sel(7); pulse_mode(); addr(1); blow();
    sel(0); chk("R9 blow under key 7 refused", trim_out, 5);

    cur_req = "R10";
    marginal_in = 1'b1;
    sel(7);  addr(6); chk("R10 code 7 flag after lock", fuse_chk_flag, 1);
    addr(1);          chk("R10 code 8 no flag", fuse_chk_flag, 0);
    addr(7);          chk("R10 code 15 flag", fuse_chk_flag, 1);
    marginal_in = 1'b0;
    idle(1);          chk("R10 no marginal no flag", fuse_chk_flag, 0);
    marginal_in = 1'b1;
    addr(1);          chk("R10 code 16 no flag", fuse_chk_flag, 0);
    marginal_in = 1'b0;

    cur_req = "R1";
    @(negedge clk); rst = 1'b1;
    idle(2);
    chk("R1 reset clears fuses", trim_out, 0);
    chk("R1 reset clears lock", locked, 0);
    @(negedge clk); rst = 1'b0;
    idle(2);
    finish_run();
  end
endmodule